// File: doc/BRIEF.md
# Configurable Sum-of-Products Unit

This block is a purely combinational sum-of-products unit. Its shape is fixed at elaboration by a packed configuration vector that describes itself. A short header gives the width of every size field. A sequence of term records follows, and each record says how wide a term's two operands are, whether the term is signed, and whether it is added to or subtracted from the total. All operand bits arrive on one concatenated bus. Each term takes its slice in turn, starting at bit 0. A second bus of single-bit increments is added on top as unsigned ones.

The result is the wrapped sum at a chosen result width, so it matches a narrow arithmetic datapath exactly. The unit is meant to sit where several multiply and add terms that share one result width should be folded into a single adder chain. The configuration parameter selects the arithmetic and the data ports only carry values.

Elaboration stops with an error in two cases: the configuration length does not equal the header plus a whole number of records, or the operand bus width does not equal the sum of all sizes the records declare. The block has no clock and no state. The output follows the inputs within the same evaluation.

Top module: `macc_cell`

## Requirements
- R1: Configuration bits 3:0 hold the unsigned field width N used by every operand-size field of every record.
- R2: Record k starts at configuration bit 4 + k*(2+2N). Its first bit is the signed flag, its second bit is the subtract flag, then come N bits of operand-A size (least significant bit first), then N bits of operand-B size (least significant bit first).
- R3: Operand bits are taken from `opnd_bus` in record order starting at bit 0. A term's A bits come first and its B bits follow directly; the next term starts right after.
- R4: A term whose B size is zero is worth operand A extended to the result width. Any other term is worth A times B.
- R5: The running total starts at zero. A term with its subtract flag set is subtracted, and any other term is added.
- R6: The signed flag covers both operands of its term: a signed term sign-extends both operands and multiplies them as signed values, and an unsigned term zero-extends them.
- R7: Every bit of `inc_bits` adds 0 or 1, as an unsigned value, to the result.
- R8: All arithmetic wraps modulo 2^RES_W.
- R9: A record whose A and B sizes are both zero has no effect on the result, whatever its flags are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_bus | input | OPND_W | Concatenated operand bits of all terms, in record order |
| inc_bits | input | BIT_W | Single-bit unsigned increments |
| result | output | RES_W | Wrapped sum of all terms and increments |

## Verification
The block holds no state, so any fault shows at `result` in the same evaluation that applies the stimulus. A record parsed at the wrong offset moves the operand slices. The damage then shows up in the fields of the following terms, so driving one term's field at a time shows which slice is wrong. An extension fault only shows when a field's top bit is set: sign extension is missing, or it was applied to an unsigned term. A subtract-sense fault flips the sign of exactly one term's contribution. Driving only the increment bus, with the operand bus at zero, isolates the increment path from every term.

// File: rtl/macc_cfg_pkg.sv
package macc_cfg_pkg;

    localparam int CFG_MAX = 512;
    localparam int HDR_W   = 4;

    typedef logic [CFG_MAX-1:0] cfgvec_t;

    function automatic int hdr_n(cfgvec_t c);
        return int'(c[HDR_W-1:0]);
    endfunction

    function automatic int rec_w(int n);
        return 2 + 2 * n;
    endfunction

    function automatic int term_cnt(int cfg_w, int n);
        return (cfg_w - HDR_W) / rec_w(n);
    endfunction

    function automatic int rec_base(int k, int n);
        return HDR_W + k * rec_w(n);
    endfunction

    function automatic int field_at(cfgvec_t c, int pos, int n);
        int v;
        v = 0;
        for (int i = 0; i < n; i++) begin
            if (c[pos + i]) v = v | (1 << i);
        end
        return v;
    endfunction

    function automatic bit term_sgn(cfgvec_t c, int k, int n);
        return c[rec_base(k, n)];
    endfunction

    function automatic bit term_sub(cfgvec_t c, int k, int n);
        return c[rec_base(k, n) + 1];
    endfunction

    function automatic int term_sa(cfgvec_t c, int k, int n);
        return field_at(c, rec_base(k, n) + 2, n);
    endfunction

    function automatic int term_sb(cfgvec_t c, int k, int n);
        return field_at(c, rec_base(k, n) + 2 + n, n);
    endfunction

    function automatic int term_off(cfgvec_t c, int k, int n);
        int s;
        s = 0;
        for (int j = 0; j < k; j++) begin
            s = s + term_sa(c, j, n) + term_sb(c, j, n);
        end
        return s;
    endfunction

endpackage

// File: rtl/macc_term.sv
module macc_term #(
    parameter int RES_W = 16,
    parameter int SA    = 4,
    parameter int SB    = 4,
    parameter bit SGN   = 1'b0,
    localparam int TW   = SA + SB
) (
    input  logic [TW-1:0]    fld,
    output logic [RES_W-1:0] val
);

    logic [RES_W-1:0] a_ext;
    logic [RES_W-1:0] b_ext;

    if (SA > 0) begin : g_a
        logic [SA-1:0] a_raw;
        assign a_raw = fld[SA-1:0];
        if (SGN) begin : g_sx
            assign a_ext = RES_W'($signed(a_raw));
        end else begin : g_zx
            assign a_ext = RES_W'(a_raw);
        end
    end else begin : g_a_none
        assign a_ext = '0;
    end

    if (SB > 0) begin : g_b
        logic [SB-1:0] b_raw;
        assign b_raw = fld[TW-1:SA];
        if (SGN) begin : g_sx
            assign b_ext = RES_W'($signed(b_raw));
        end else begin : g_zx
            assign b_ext = RES_W'(b_raw);
        end
        assign val = a_ext * b_ext;
    end else begin : g_pass
        assign b_ext = '0;
        assign val   = a_ext;
    end

endmodule

// File: rtl/macc_bitcount.sv
module macc_bitcount #(
    parameter int BIT_W = 3,
    parameter int RES_W = 16
) (
    input  logic [BIT_W-1:0] bits,
    output logic [RES_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < BIT_W; i++) begin
            count = count + RES_W'(bits[i]);
        end
    end

endmodule

// File: rtl/macc_accum.sv
module macc_accum #(
    parameter int             TS       = 4,
    parameter int             RES_W    = 16,
    parameter logic [TS-1:0]  SUB_MASK = '0
) (
    input  logic [TS-1:0][RES_W-1:0] term_val,
    input  logic [RES_W-1:0]         inc_count,
    output logic [RES_W-1:0]         result
);

    logic [TS:0][RES_W-1:0] acc;

    assign acc[0] = '0;

    for (genvar k = 0; k < TS; k++) begin : g_stage
        if (SUB_MASK[k]) begin : g_sub
            assign acc[k+1] = acc[k] - term_val[k];
        end else begin : g_add
            assign acc[k+1] = acc[k] + term_val[k];
        end
    end

    assign result = acc[TS] + inc_count;

endmodule

// File: rtl/macc_cell.sv
module macc_cell
    import macc_cfg_pkg::*;
#(
    parameter int               CFG_W  = 44,
    parameter logic [CFG_W-1:0] CFG    = {4'd0, 4'd5, 1'b1, 1'b1,
                                          4'd0, 4'd6, 1'b0, 1'b0,
                                          4'd5, 4'd3, 1'b1, 1'b0,
                                          4'd4, 4'd4, 1'b0, 1'b1,
                                          4'd4},
    parameter int               OPND_W = 27,
    parameter int               BIT_W  = 3,
    parameter int               RES_W  = 16
) (
    input  logic [OPND_W-1:0] opnd_bus,
    input  logic [BIT_W-1:0]  inc_bits,
    output logic [RES_W-1:0]  result
);

    localparam cfgvec_t CFGX = cfgvec_t'(CFG);
    localparam int N    = hdr_n(CFGX);
    localparam int T    = term_cnt(CFG_W, N);
    localparam int TS   = (T > 0) ? T : 1;
    localparam int USED = term_off(CFGX, T, N);

    if (CFG_W > CFG_MAX) begin : g_err_big
        $error("configuration longer than supported maximum");
    end
    if (CFG_W < HDR_W || ((CFG_W - HDR_W) % rec_w(N)) != 0) begin : g_err_len
        $error("configuration length is not header plus whole records");
    end
    if (USED != OPND_W) begin : g_err_bus
        $error("operand bus width differs from sum of declared sizes");
    end

    function automatic logic [TS-1:0] mk_sub_mask();
        logic [TS-1:0] m;
        m = '0;
        for (int k = 0; k < T; k++) begin
            m[k] = term_sub(CFGX, k, N);
        end
        return m;
    endfunction

    localparam logic [TS-1:0] SUB_MASK = mk_sub_mask();

    logic [TS-1:0][RES_W-1:0] term_val;
    logic [RES_W-1:0]         inc_count;

    for (genvar k = 0; k < TS; k++) begin : g_term
        localparam int  SA  = (k < T) ? term_sa(CFGX, k, N) : 0;
        localparam int  SB  = (k < T) ? term_sb(CFGX, k, N) : 0;
        localparam bit  SGN = (k < T) ? term_sgn(CFGX, k, N) : 1'b0;
        localparam int  OFF = term_off(CFGX, k, N);
        localparam int  TW  = SA + SB;
        if (TW > 0) begin : g_live
            macc_term #(
                .RES_W (RES_W),
                .SA    (SA),
                .SB    (SB),
                .SGN   (SGN)
            ) u_term (
                .fld (opnd_bus[OFF +: TW]),
                .val (term_val[k])
            );
        end else begin : g_idle
            assign term_val[k] = '0;
        end
    end

    macc_bitcount #(
        .BIT_W (BIT_W),
        .RES_W (RES_W)
    ) u_bitcount (
        .bits  (inc_bits),
        .count (inc_count)
    );

    macc_accum #(
        .TS       (TS),
        .RES_W    (RES_W),
        .SUB_MASK (SUB_MASK)
    ) u_accum (
        .term_val  (term_val),
        .inc_count (inc_count),
        .result    (result)
    );

endmodule

// File: rtl/macc_cell_chk.sv
module macc_cell_chk
    import macc_cfg_pkg::*;
#(
    parameter int               CFG_W  = 44,
    parameter logic [CFG_W-1:0] CFG    = '0,
    parameter int               OPND_W = 27,
    parameter int               BIT_W  = 3,
    parameter int               RES_W  = 16,
    localparam cfgvec_t         CFGX   = cfgvec_t'(CFG),
    localparam int              N      = hdr_n(CFGX),
    localparam int              T      = term_cnt(CFG_W, N),
    localparam int              TS     = (T > 0) ? T : 1
) (
    input logic [OPND_W-1:0]          opnd_bus,
    input logic [BIT_W-1:0]           inc_bits,
    input logic [RES_W-1:0]           result,
    input logic [TS-1:0][RES_W-1:0]   term_val
);

    localparam logic [RES_W-1:0] ONES = '1;

    logic [RES_W-1:0] exp_sum;
    logic [RES_W-1:0] inc_sum;

    always_comb begin
        inc_sum = RES_W'($countones(inc_bits));
        exp_sum = '0;
        for (int k = 0; k < T; k++) begin
            if (term_sub(CFGX, k, N)) exp_sum = exp_sum - term_val[k];
            else                      exp_sum = exp_sum + term_val[k];
        end
        exp_sum = exp_sum + inc_sum;
    end

    always_comb begin
        // R5: an all-zero stimulus leaves the total at its zero start
        p_zero_start_r5: assert (!(opnd_bus == '0 && inc_bits == '0) || result == '0)
            else $error("zero inputs gave nonzero result");
        // R7: with no operand bits set the output is the increment count
        p_inc_only_r7: assert (opnd_bus != '0 || result == inc_sum)
            else $error("increment-only result mismatch");
        // R8: chain output equals wrapped signed sum of the term values
        p_wrap_sum_r8: assert (result == exp_sum)
            else $error("result differs from wrapped term sum");
    end

    for (genvar k = 0; k < T; k++) begin : g_chk
        localparam int SA  = term_sa(CFGX, k, N);
        localparam int SB  = term_sb(CFGX, k, N);
        localparam bit SGN = term_sgn(CFGX, k, N);
        localparam int TW  = SA + SB;
        if (!SGN && TW > 0 && TW < RES_W) begin : g_zx
            always_comb begin
                p_zext_bound_r6: assert ((term_val[k] >> TW) == '0)
                    else $error("unsigned term exceeds operand bits");
            end
        end
        if (SGN && SB == 0 && SA > 0 && SA < RES_W) begin : g_sx
            logic [RES_W-1:0] hi;
            assign hi = term_val[k] >> (SA - 1);
            always_comb begin
                p_sext_fill_r6: assert (hi == '0 || hi == (ONES >> (SA - 1)))
                    else $error("signed pass term not sign-extended");
            end
        end
        if (TW == 0) begin : g_zero
            always_comb begin
                p_empty_term_r9: assert (term_val[k] == '0)
                    else $error("empty record produced a value");
            end
        end
    end

endmodule

bind macc_cell macc_cell_chk #(
    .CFG_W  (CFG_W),
    .CFG    (CFG),
    .OPND_W (OPND_W),
    .BIT_W  (BIT_W),
    .RES_W  (RES_W)
) u_chk (
    .opnd_bus (opnd_bus),
    .inc_bits (inc_bits),
    .result   (result),
    .term_val (term_val)
);

// File: tb/macc_cell_bench.sv
module macc_cell_bench;

    localparam int CFG_W_A = 44;
    localparam logic [CFG_W_A-1:0] CFG_A = {4'd0, 4'd5, 1'b1, 1'b1,
                                            4'd0, 4'd6, 1'b0, 1'b0,
                                            4'd5, 4'd3, 1'b1, 1'b0,
                                            4'd4, 4'd4, 1'b0, 1'b1,
                                            4'd4};
    localparam int OPND_A = 27;
    localparam int BITS_A = 3;
    localparam int RES_A  = 16;

    localparam int CFG_W_B = 36;
    localparam logic [CFG_W_B-1:0] CFG_B = {3'd7, 3'd3, 1'b1, 1'b1,
                                            3'd0, 3'd7, 1'b0, 1'b1,
                                            3'd6, 3'd7, 1'b0, 1'b0,
                                            3'd0, 3'd0, 1'b1, 1'b1,
                                            4'd3};
    localparam int OPND_B = 30;
    localparam int BITS_B = 5;
    localparam int RES_B  = 12;

    // independent term descriptions for the reference model
    int sa_a [4] = '{4, 3, 6, 5};
    int sb_a [4] = '{4, 5, 0, 0};
    bit sg_a [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
    bit su_a [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    int sa_b [4] = '{0, 7, 7, 3};
    int sb_b [4] = '{0, 6, 0, 7};
    bit sg_b [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
    bit su_b [4] = '{1'b1, 1'b0, 1'b0, 1'b1};

    logic clk;
    logic rst_n;
    logic [OPND_A-1:0] opnd_a;
    logic [BITS_A-1:0] bits_a;
    logic [RES_A-1:0]  res_a;
    logic [OPND_B-1:0] opnd_b;
    logic [BITS_B-1:0] bits_b;
    logic [RES_B-1:0]  res_b;

    int checks;
    int errors;
    bit done;

    typedef struct {
        bit      inst_b;
        longint  expv;
        string   tag;
    } item_t;

    item_t sb_q[$];

    macc_cell #(
        .CFG_W(CFG_W_A), .CFG(CFG_A), .OPND_W(OPND_A), .BIT_W(BITS_A), .RES_W(RES_A)
    ) u_macc_cell (
        .opnd_bus(opnd_a), .inc_bits(bits_a), .result(res_a)
    );

    macc_cell #(
        .CFG_W(CFG_W_B), .CFG(CFG_B), .OPND_W(OPND_B), .BIT_W(BITS_B), .RES_W(RES_B)
    ) u_macc_cell_b (
        .opnd_bus(opnd_b), .inc_bits(bits_b), .result(res_b)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic longint ref_eval(bit use_b, logic [63:0] bus, logic [7:0] bits);
        longint acc, a, b, v;
        int off, sa, sb, nb, w;
        bit sg, su;
        acc = 0;
        off = 0;
        nb  = use_b ? BITS_B : BITS_A;
        w   = use_b ? RES_B : RES_A;
        for (int k = 0; k < 4; k++) begin
            sa = use_b ? sa_b[k] : sa_a[k];
            sb = use_b ? sb_b[k] : sb_a[k];
            sg = use_b ? sg_b[k] : sg_a[k];
            su = use_b ? su_b[k] : su_a[k];
            a = longint'((bus >> off) & ((64'd1 << sa) - 64'd1));
            off = off + sa;
            b = longint'((bus >> off) & ((64'd1 << sb) - 64'd1));
            off = off + sb;
            if (sg && sa > 0 && ((a >> (sa - 1)) & 1) != 0) a = a - (longint'(1) << sa);
            if (sg && sb > 0 && ((b >> (sb - 1)) & 1) != 0) b = b - (longint'(1) << sb);
            v = (sb == 0) ? a : a * b;
            acc = su ? acc - v : acc + v;
        end
        for (int i = 0; i < nb; i++) acc = acc + longint'(bits[i]);
        return acc & ((longint'(1) << w) - 1);
    endfunction

    task automatic drive(logic [63:0] bus_a, logic [7:0] ib_a,
                         logic [63:0] bus_b, logic [7:0] ib_b, string tag);
        item_t it;
        @(posedge clk);
        opnd_a = bus_a[OPND_A-1:0];
        bits_a = ib_a[BITS_A-1:0];
        opnd_b = bus_b[OPND_B-1:0];
        bits_b = ib_b[BITS_B-1:0];
        it.inst_b = 1'b0;
        it.expv = ref_eval(1'b0, 64'(opnd_a), 8'(bits_a));
        it.tag = tag;
        sb_q.push_back(it);
        it.inst_b = 1'b1;
        it.expv = ref_eval(1'b1, 64'(opnd_b), 8'(bits_b));
        sb_q.push_back(it);
    endtask

    // monitor: pops expected items between clock edges
    initial begin
        item_t it;
        longint got;
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                got = it.inst_b ? longint'(res_b) : longint'(res_a);
                checks++;
                if (got != it.expv) begin
                    errors++;
                    $display("FAIL %s (%s): got %0h expected %0h",
                             it.tag, it.inst_b ? "cfgB" : "cfgA", got, it.expv);
                end
            end
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] ra, rb;
        checks = 0;
        errors = 0;
        done = 1'b0;
        rst_n = 1'b0;
        opnd_a = '0; bits_a = '0; opnd_b = '0; bits_b = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R5: zero stimulus, total starts at zero
        drive(64'd0, 8'd0, 64'd0, 8'd0, "R5 zero start");
        // R7: increments only, all set
        drive(64'd0, 8'hFF, 64'd0, 8'hFF, "R7 all increments");
        drive(64'd0, 8'h05, 64'd0, 8'h0A, "R7 partial increments");
        // R6: signed product of -8 by 7 (cfgA term0), signed pass -4 (cfgB term2 bits 19:13)
        drive(64'h78, 8'd0, 64'h7C << 13, 8'd0, "R6 signed extension");
        // R5: unsigned subtracted product (cfgA term1 bits 15:8)
        drive(64'hFF00, 8'd0, 64'd0, 8'd0, "R5 subtract term");
        // R4: pass term, B size zero (cfgA term2 bits 21:16 all ones, zero-extended)
        drive(64'h3F << 16, 8'd0, 64'd0, 8'd0, "R4 pass-through term");
        // R6: signed subtracted pass term -16 (cfgA term3 bits 26:22)
        drive(64'h10 << 22, 8'd1, 64'd0, 8'd0, "R6 signed subtract pass");
        // R8: wrap, cfgB 127*63 exceeds 12 bits; cfgA all ones
        drive(64'h7FF_FFFF, 8'h7, 64'h1FFF, 8'd0, "R8 wraparound");
        // R9: cfgB empty first record, data begins with term1 at bit 0
        drive(64'd0, 8'd0, 64'h5, 8'd0, "R9 empty record ignored");
        // R3: distinct values in each field
        drive(64'h4A3_5D2C, 8'd2, 64'h2ABC_1234, 8'd3, "R3 operand slicing");
        // R1 R2: random operands, two different headers and record layouts
        for (int i = 0; i < 60; i++) begin
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            drive(ra, 8'($urandom()), rb, 8'($urandom()), "R1/R2/R4/R6 random");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule